// File: doc/BRIEF.md
# Packed Byte Add/Subtract Unit

This execution unit treats each source register word as a row of independent 8-bit lanes and applies one of ten lane-wise add or subtract operations. Each lane is handled in isolation: no carry or borrow ever moves from one lane into the next. The operation families are plain modulo-256 arithmetic, halving arithmetic (signed or unsigned) that returns the widened sum or difference shifted right by one, and saturating arithmetic (signed or unsigned) that clamps each lane to its representable range.

The unit takes the 32-bit instruction word and two operand words, decodes the instruction itself and registers the result, a recognition flag and a sticky saturation flag on the next rising clock edge. The word width is a parameter (32 or 64 bits, giving 4 or 8 lanes). Software clears the sticky flag through a dedicated input.

Top module: `pbyte_addsub`

## Requirements
- R1: An instruction is recognised when bits [6:0] = 1111111, bits [14:12] = 000 and bits [31:25] hold one of: 0100100 wrap add, 0100101 wrap sub, 0000100 signed halving add, 0000101 signed halving sub, 0010100 unsigned halving add, 0010101 unsigned halving sub, 0001100 signed saturating add, 0001101 signed saturating sub, 0011100 unsigned saturating add, 0011101 unsigned saturating sub. Bits [24:15] and [11:7] do not affect the result.
- R2: Wrap add returns (a+b) mod 256 in each lane, with no carry into the neighbouring lane.
- R3: Wrap sub returns (a-b) mod 256 in each lane, with no borrow from the neighbouring lane.
- R4: Signed halving forms read lanes as two's complement and return the low 8 bits of the 9-bit sum or difference shifted right arithmetically by one.
- R5: Unsigned halving forms read lanes as unsigned and return the low 8 bits of the widened sum or difference shifted right by one; for subtraction the difference is signed, so the shift is arithmetic (0x00 - 0x01 gives 0xFF).
- R6: Signed saturating forms clamp each lane to -128..127 (0x80..0x7F).
- R7: Unsigned saturating forms clamp each lane to 0..255, so an underflowing subtraction yields 0x00 and an overflowing addition yields 0xFF.
- R8: The sticky flag is set by a recognised saturating instruction in which any lane clamps, and stays set until the clear input is high; a clamp in the same cycle as a clear leaves the flag set.
- R9: An unrecognised instruction gives valid low and an all-zero result, and never changes the sticky flag.
- R10: Result, valid and sticky flag are registered: they reflect the inputs present at the previous rising edge, and synchronous reset drives all three to zero.
- R11: The parameter XLEN (32 or 64) sets the word width and the lane count XLEN/8; every lane obeys the rules above independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word to decode |
| src_a | input | XLEN | First operand word |
| src_b | input | XLEN | Second operand word |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| res_q | output | XLEN | Registered lane-wise result |
| valid_q | output | 1 | Registered recognition flag |
| sat_q | output | 1 | Sticky saturation flag |

## Verification
Every output of this unit is due exactly one rising edge after the instruction and operands are presented: result, valid flag and sticky flag all update at that edge and nothing takes longer. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each vector is checked against the edge that captured it and the next vector is already on the inputs. The sticky flag is modelled in the bench as a running state updated once per vector, including the vectors where the clear input is raised, and compared after every edge.

// File: rtl/pbyte_pkg.sv
package pbyte_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    CLS_WRAP  = 3'd0,
    CLS_SHALF = 3'd1,
    CLS_UHALF = 3'd2,
    CLS_SSAT  = 3'd3,
    CLS_USAT  = 3'd4
  } op_class_e;
endpackage

// File: rtl/pbyte_decode.sv
module pbyte_decode
  import pbyte_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit,
  output op_class_e   cls,
  output logic        is_sub
);
  logic       major_ok;
  logic [5:0] f7_hi;
  logic       unused_fields;

  assign major_ok      = (insn[6:0] == 7'b1111111) && (insn[14:12] == 3'b000);
  assign f7_hi         = insn[31:26];
  assign is_sub        = insn[25];
  assign unused_fields = ^{insn[24:15], insn[11:7]};

  always_comb begin
    hit = major_ok;
    cls = CLS_WRAP;
    case (f7_hi)
      6'b010010: cls = CLS_WRAP;
      6'b000010: cls = CLS_SHALF;
      6'b001010: cls = CLS_UHALF;
      6'b000110: cls = CLS_SSAT;
      6'b001110: cls = CLS_USAT;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pbyte_wrap.sv
module pbyte_wrap #(
  parameter int XLEN   = 64,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] diff
);
  localparam int NLANES = XLEN / LANE_W;

  logic [XLEN-1:0] msb_mask;

  // Top bit of every lane set; the bulk adder works on the low bits only,
  // and the lane top bits are patched back with an XOR.
  always_comb begin
    msb_mask = '0;
    for (int i = 0; i < NLANES; i++) msb_mask[i*LANE_W + LANE_W-1] = 1'b1;
  end

  assign sum  = ((a & ~msb_mask) + (b & ~msb_mask)) ^ ((a ^ b) & msb_mask);
  assign diff = ((a | msb_mask) - (b & ~msb_mask)) ^ (~(a ^ b) & msb_mask);
endmodule

// File: rtl/pbyte_lane.sv
module pbyte_lane
  import pbyte_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  op_class_e     cls,
  input  logic          is_sub,
  output logic [LW-1:0] res,
  output logic          clamp
);
  localparam int EW = LW + 2;

  logic          unsigned_op;
  logic [EW-1:0] ea, eb, wide;
  logic          neg, sovf;

  assign unsigned_op = (cls == CLS_UHALF) || (cls == CLS_USAT);
  assign ea   = unsigned_op ? {2'b00, a} : {{2{a[LW-1]}}, a};
  assign eb   = unsigned_op ? {2'b00, b} : {{2{b[LW-1]}}, b};
  assign wide = is_sub ? (ea - eb) : (ea + eb);
  assign neg  = wide[EW-1];
  assign sovf = !((wide[EW-1:LW-1] == '0) || (wide[EW-1:LW-1] == '1));

  always_comb begin
    res   = wide[LW-1:0];
    clamp = 1'b0;
    case (cls)
      CLS_SHALF, CLS_UHALF: res = wide[LW:1];
      CLS_SSAT: if (sovf) begin
        clamp = 1'b1;
        res   = neg ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
      end
      CLS_USAT: if (neg) begin
        clamp = 1'b1;
        res   = '0;
      end else if (wide[LW]) begin
        clamp = 1'b1;
        res   = '1;
      end
      default: res = wide[LW-1:0];
    endcase
  end
endmodule

// File: rtl/pbyte_addsub.sv
module pbyte_addsub
  import pbyte_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            sat_clr,
  output logic [XLEN-1:0] res_q,
  output logic            valid_q,
  output logic            sat_q
);
  localparam int NLANES = XLEN / LANE_W;

  logic            dec_hit, dec_sub;
  op_class_e       dec_cls;
  logic [XLEN-1:0] wrap_sum, wrap_diff, lane_res, next_res;
  logic [NLANES-1:0] lane_clamp;
  logic            any_clamp;

  pbyte_decode u_dec (
    .insn(insn), .hit(dec_hit), .cls(dec_cls), .is_sub(dec_sub)
  );

  pbyte_wrap #(.XLEN(XLEN), .LANE_W(LANE_W)) u_wrap (
    .a(src_a), .b(src_b), .sum(wrap_sum), .diff(wrap_diff)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    pbyte_lane #(.LW(LANE_W)) u_lane (
      .a      (src_a[g*LANE_W +: LANE_W]),
      .b      (src_b[g*LANE_W +: LANE_W]),
      .cls    (dec_cls),
      .is_sub (dec_sub),
      .res    (lane_res[g*LANE_W +: LANE_W]),
      .clamp  (lane_clamp[g])
    );
  end

  assign any_clamp = dec_hit && (|lane_clamp);

  always_comb begin
    if (!dec_hit)               next_res = '0;
    else if (dec_cls == CLS_WRAP) next_res = dec_sub ? wrap_diff : wrap_sum;
    else                        next_res = lane_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      res_q   <= next_res;
      valid_q <= dec_hit;
      sat_q   <= (sat_q && !sat_clr) || any_clamp;
    end
  end

  // R9: a wrong major opcode is never reported as recognised
  a_r9_bad_major: assert property (@(posedge clk) disable iff (rst)
    (insn[6:0] != 7'b1111111) |=> !valid_q);

  // R9: no result leaks out when the instruction was not recognised
  a_r9_zero_result: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (res_q == '0));

  // R8: flag holds while no clear is requested
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sat_q && !sat_clr) |=> sat_q);

  // R8: a rising flag needs a lane that clamped
  a_r8_sticky_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_q) |-> $past(any_clamp));

  // R8: clear without a new clamp drops the flag
  a_r8_sticky_clear: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !any_clamp) |=> !sat_q);

  // R6, R7: clamps only come from saturating classes
  a_r7_clamp_class: assert property (@(posedge clk) disable iff (rst)
    (|lane_clamp) |-> (dec_cls == CLS_SSAT || dec_cls == CLS_USAT));
endmodule

// File: tb/sim_pbyte_addsub.sv
`timescale 1ns/1ps
module sim_pbyte_addsub;
  localparam int XLEN = 64;
  localparam int NL   = XLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     insn = '0;
  logic [XLEN-1:0] src_a = '0, src_b = '0;
  logic            sat_clr = 1'b0;
  logic [XLEN-1:0] res_q;
  logic            valid_q, sat_q;

  int total = 0, bad = 0;
  bit done = 0;
  bit sticky_exp = 0;

  always #4 clk = ~clk;

  pbyte_addsub #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .insn(insn), .src_a(src_a), .src_b(src_b),
    .sat_clr(sat_clr), .res_q(res_q), .valid_q(valid_q), .sat_q(sat_q)
  );

  function automatic logic [6:0] f7_of(int k);
    int c = k >> 1;
    return {1'b0, c == 0, (c == 2) || (c == 4), (c == 3) || (c == 4), 1'b1, 1'b0, k[0]};
  endfunction

  function automatic logic [31:0] insn_of(int k, logic [9:0] regs);
    return {f7_of(k), regs, 3'b000, regs[4:0], 7'b1111111};
  endfunction

  function automatic logic [7:0] ref_lane(int c, bit sub, logic [7:0] a, logic [7:0] b,
                                          output bit clamp);
    int ea, eb, r;
    clamp = 0;
    ea = (c == 1 || c == 3) ? int'($signed(a)) : int'(a);
    eb = (c == 1 || c == 3) ? int'($signed(b)) : int'(b);
    r  = sub ? ea - eb : ea + eb;
    case (c)
      1, 2: r = r >>> 1;
      3: if (r > 127) begin r = 127; clamp = 1; end
         else if (r < -128) begin r = -128; clamp = 1; end
      4: if (r > 255) begin r = 255; clamp = 1; end
         else if (r < 0) begin r = 0; clamp = 1; end
      default: ;
    endcase
    return r[7:0];
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
  task automatic run_op(int k, logic [XLEN-1:0] a, logic [XLEN-1:0] b, bit clr, string req);
    logic [XLEN-1:0] exp;
    bit any, cl;
    any = 0;
    for (int i = 0; i < NL; i++) begin
      exp[i*8 +: 8] = ref_lane(k >> 1, k[0], a[i*8 +: 8], b[i*8 +: 8], cl);
      any |= cl;
    end
    insn = insn_of(k, 10'(k * 97 + 13)); src_a = a; src_b = b; sat_clr = clr;
    @(negedge clk);
    sticky_exp = (sticky_exp && !clr) || any;
    check(req, res_q, exp);
    check("R1 valid", {63'b0, valid_q}, 64'd1);
    check("R8 sticky", {63'b0, sat_q}, {63'b0, sticky_exp});
  endtask

  task automatic run_bad(logic [31:0] w, bit clr);
    insn = w; src_a = 64'h7F80FF0012345678; src_b = 64'h01017F01FFEEDDCC; sat_clr = clr;
    @(negedge clk);
    sticky_exp = sticky_exp && !clr;
    check("R9 result", res_q, '0);
    check("R9 valid", {63'b0, valid_q}, 64'd0);
    check("R9 sticky", {63'b0, sat_q}, {63'b0, sticky_exp});
  endtask

  string names[10] = '{"R2 wrap add", "R3 wrap sub", "R4 shalf add", "R4 shalf sub",
                       "R5 uhalf add", "R5 uhalf sub", "R6 ssat add", "R6 ssat sub",
                       "R7 usat add", "R7 usat sub"};

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset res", res_q, '0);
    check("R10 reset valid", {63'b0, valid_q}, 64'd0);
    check("R10 reset sat", {63'b0, sat_q}, 64'd0);
    rst = 1'b0;

    // Boundary lanes: 7F+01, 80-01, FF+01, 00-01 across all ten forms (R11: all 8 lanes)
    for (int k = 0; k < 10; k++) begin
      run_op(k, 64'h7F80FF007F80FF00, 64'h0101010101010101, 1'b0, names[k]);
      run_op(k, 64'h00FF807F00FF807F, 64'h01FF0180FF7F8001, 1'b1, names[k]);
    end
    // R5: ursub 0x00 - 0x01 is 0xFF explicitly
    run_op(5, 64'h0, 64'h0101010101010101, 1'b1, "R5 ursub 00-01");
    check("R5 ursub value", res_q, 64'hFFFFFFFFFFFFFFFF);

    // R8: clamp then clear, and clamp during clear keeps the flag
    run_op(8, 64'hFF, 64'h01, 1'b0, "R8 set");
    check("R8 set flag", {63'b0, sat_q}, 64'd1);
    run_op(0, 64'h1, 64'h1, 1'b0, "R8 hold");
    check("R8 hold flag", {63'b0, sat_q}, 64'd1);
    run_op(0, 64'h1, 64'h1, 1'b1, "R8 clear");
    check("R8 cleared", {63'b0, sat_q}, 64'd0);
    run_op(7, 64'h80, 64'h01, 1'b1, "R8 clamp wins");
    check("R8 clamp over clear", {63'b0, sat_q}, 64'd1);

    // R9: unrecognised words leave the flag and give zero
    run_bad(insn_of(6, 10'h3) & ~32'h1, 1'b0);
    run_bad(insn_of(6, 10'h3) | 32'h0000_1000, 1'b0);
    run_bad({7'b0100110, 25'h0000_07F}, 1'b0);
    run_bad({7'b0111100, 25'h0000_07F}, 1'b1);
    check("R9 flag cleared", {63'b0, sat_q}, 64'd0);

    // R1..R7, R11: sweep of every first operand against sixteen second operands
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 16; s++)
        for (int k = 0; k < 10; k++) begin
          logic [XLEN-1:0] va, vb;
          for (int i = 0; i < NL; i++) begin
            va[i*8 +: 8] = 8'(a + i * 29);
            vb[i*8 +: 8] = 8'(s * 17 + 3 + i * 71);
          end
          run_op(k, va, vb, (a % 7) == 3 && k == 0, names[k]);
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule